// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic unit of a small accumulator-style processor core. One operand is always the working register. The other operand is a file-register value or an immediate literal, picked by a select input. Single-operand operations work on that same second operand. The result is combinational. The block also returns the new Carry, Digit Carry and Zero values, and a write enable for each flag that shows which flags the current operation touches.

Three status flags are kept in registers inside the block. On a clock edge where an operation is valid, only the enabled flags load their new values. The other flags keep their old values. The rotate operations take their incoming bit from the stored Carry. In subtraction, Carry and Digit Carry report an inverted borrow. The block does not write the result anywhere. It raises one of two write strobes, for the working register or for the file register, according to a destination bit. The register file and the instruction decoder sit outside the block.

Top module: `alu8_flags`

## Requirements
- R1: Operation code 0 (add) gives result = W + B modulo 256. Carry is the carry out of bit 7, Digit Carry is the carry from bit 3 into bit 4, and Zero is updated. All three write enables are high.
- R2: Operation code 1 (subtract) gives result = B − W modulo 256. Carry is 1 exactly when B ≥ W as unsigned values. Digit Carry is 1 exactly when B[3:0] ≥ W[3:0]. Zero is updated, and all three enables are high.
- R3: Operation codes 2, 3 and 4 give W AND B, W OR B and W XOR B. Only the Zero enable is high.
- R4: Operation codes 5 (complement ~B), 6 (B+1), 7 (B−1), 11 (clear to 0x00) and 12 (move B) update only Zero. Carry is not touched by the increment or decrement wrap-around.
- R5: Operation code 8 (rotate left) gives {B[6:0], C}, and the new Carry is B[7]. Operation code 9 (rotate right) gives {C, B[7:1]}, and the new Carry is B[0]. C is the stored Carry. Only the Carry enable is high, and Zero keeps its value.
- R6: Operation code 10 swaps the two nibbles of B. Operation codes 13 to 15 pass B through. None of these operations enables a flag.
- R7: B is the literal input when the literal-select input is 1, and the file input when it is 0.
- R8: A stored flag changes only on a rising clock edge where the operation is valid and that flag's enable is high. Otherwise it holds its value.
- R9: All flag write enables are low when no valid operation is present.
- R10: With a valid operation, destination bit 0 raises the working-register write strobe and destination bit 1 raises the file write strobe. With no valid operation, neither strobe is raised.
- R11: Reset (active low) clears all three stored flags to 0.
- R12: When the Zero flag is updated, it becomes 1 exactly when the 8-bit result is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | A valid operation is present this cycle |
| opCode | input | 4 | Operation code |
| wReg | input | 8 | Working register value |
| fileVal | input | 8 | File-register operand |
| litVal | input | 8 | Immediate literal operand |
| useLit | input | 1 | 1 selects the literal as operand B |
| destFile | input | 1 | 1 routes the result to the file register |
| result | output | 8 | Combinational result |
| carryNext | output | 1 | New Carry value |
| dcNext | output | 1 | New Digit Carry value |
| zeroNext | output | 1 | New Zero value |
| carryWe | output | 1 | Carry write enable |
| dcWe | output | 1 | Digit Carry write enable |
| zeroWe | output | 1 | Zero write enable |
| carryFlag | output | 1 | Stored Carry |
| dcFlag | output | 1 | Stored Digit Carry |
| zeroFlag | output | 1 | Stored Zero |
| writeW | output | 1 | Write result to working register |
| writeF | output | 1 | Write result to file register |

## Verification
A wrong decode strobe shows up at the ports in the same cycle, as a wrong result or a wrong enable pattern. A stored flag that was corrupted, or updated when it should not have been, shows up one edge later, on the flag outputs. It also spreads into the next rotate, because the rotate's result and the new Carry both depend on the stored Carry. The vector sequence chains rotates after arithmetic and logical operations so that a flag updated by mistake changes a later result. It also checks that a flag with its enable low keeps its value across the edge.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_IOR  = 4'd3,
    OP_XOR  = 4'd4,
    OP_COM  = 4'd5,
    OP_INC  = 4'd6,
    OP_DEC  = 4'd7,
    OP_RLC  = 4'd8,
    OP_RRC  = 4'd9,
    OP_SWAP = 4'd10,
    OP_CLR  = 4'd11,
    OP_MOV  = 4'd12,
    OP_P13  = 4'd13,
    OP_P14  = 4'd14,
    OP_P15  = 4'd15
  } aluOp_e;

  // second adder input source
  typedef enum logic [1:0] {
    ADDB_W,
    ADDB_NOTW,
    ADDB_ZERO,
    ADDB_ONES
  } addB_e;

  typedef enum logic [3:0] {
    RES_ADDER,
    RES_AND,
    RES_IOR,
    RES_XOR,
    RES_NOT,
    RES_RLC,
    RES_RRC,
    RES_SWAP,
    RES_ZERO,
    RES_PASS
  } resSel_e;

  typedef struct packed {
    addB_e   addB;
    logic    addCin;
    resSel_e resSel;
    logic    cWe;
    logic    dcWe;
    logic    zWe;
  } aluStrobe_t;

endpackage

// File: rtl/alu8_ctrl.sv
module alu8_ctrl
  import alu8_pkg::*;
(
  input  logic       opValid,
  input  logic [3:0] opCode,
  output aluStrobe_t strobe
);

  aluStrobe_t raw;

  always_comb begin
    raw        = '0;
    raw.addB   = ADDB_W;
    raw.addCin = 1'b0;
    raw.resSel = RES_PASS;
    unique case (aluOp_e'(opCode))
      OP_ADD: begin
        raw.resSel = RES_ADDER;
        {raw.cWe, raw.dcWe, raw.zWe} = 3'b111;
      end
      OP_SUB: begin
        // B + ~W + 1: carry out means no borrow
        raw.addB   = ADDB_NOTW;
        raw.addCin = 1'b1;
        raw.resSel = RES_ADDER;
        {raw.cWe, raw.dcWe, raw.zWe} = 3'b111;
      end
      OP_AND: begin raw.resSel = RES_AND;  raw.zWe = 1'b1; end
      OP_IOR: begin raw.resSel = RES_IOR;  raw.zWe = 1'b1; end
      OP_XOR: begin raw.resSel = RES_XOR;  raw.zWe = 1'b1; end
      OP_COM: begin raw.resSel = RES_NOT;  raw.zWe = 1'b1; end
      OP_INC: begin
        raw.addB   = ADDB_ZERO;
        raw.addCin = 1'b1;
        raw.resSel = RES_ADDER;
        raw.zWe    = 1'b1;
      end
      OP_DEC: begin
        raw.addB   = ADDB_ONES;
        raw.resSel = RES_ADDER;
        raw.zWe    = 1'b1;
      end
      OP_RLC:  begin raw.resSel = RES_RLC;  raw.cWe = 1'b1; end
      OP_RRC:  begin raw.resSel = RES_RRC;  raw.cWe = 1'b1; end
      OP_SWAP: begin raw.resSel = RES_SWAP; end
      OP_CLR:  begin raw.resSel = RES_ZERO; raw.zWe = 1'b1; end
      OP_MOV:  begin raw.resSel = RES_PASS; raw.zWe = 1'b1; end
      default: begin raw.resSel = RES_PASS; end
    endcase
  end

  always_comb begin
    strobe      = raw;
    strobe.cWe  = raw.cWe  & opValid;
    strobe.dcWe = raw.dcWe & opValid;
    strobe.zWe  = raw.zWe  & opValid;
  end

endmodule

// File: rtl/alu8_dp.sv
module alu8_dp
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  aluStrobe_t        strobe,
  input  logic [DATA_W-1:0] wVal,
  input  logic [DATA_W-1:0] bVal,
  input  logic              carryIn,
  output logic [DATA_W-1:0] result,
  output logic              carryNew,
  output logic              dcNew,
  output logic              zeroNew
);

  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] addOp;
  logic [DATA_W:0]   sumFull;
  logic [HALF_W:0]   sumLow;
  logic [DATA_W-1:0] swapped;

  always_comb begin
    unique case (strobe.addB)
      ADDB_W:    addOp = wVal;
      ADDB_NOTW: addOp = ~wVal;
      ADDB_ZERO: addOp = '0;
      default:   addOp = '1;
    endcase
  end

  assign sumFull = {1'b0, bVal} + {1'b0, addOp} + {{DATA_W{1'b0}}, strobe.addCin};
  assign sumLow  = {1'b0, bVal[HALF_W-1:0]} + {1'b0, addOp[HALF_W-1:0]}
                 + {{HALF_W{1'b0}}, strobe.addCin};

  generate
    for (genvar i = 0; i < HALF_W; i++) begin : g_swap
      assign swapped[i]          = bVal[i + HALF_W];
      assign swapped[i + HALF_W] = bVal[i];
    end
  endgenerate

  always_comb begin
    unique case (strobe.resSel)
      RES_ADDER: result = sumFull[DATA_W-1:0];
      RES_AND:   result = wVal & bVal;
      RES_IOR:   result = wVal | bVal;
      RES_XOR:   result = wVal ^ bVal;
      RES_NOT:   result = ~bVal;
      RES_RLC:   result = {bVal[DATA_W-2:0], carryIn};
      RES_RRC:   result = {carryIn, bVal[DATA_W-1:1]};
      RES_SWAP:  result = swapped;
      RES_ZERO:  result = '0;
      default:   result = bVal;
    endcase
  end

  always_comb begin
    unique case (strobe.resSel)
      RES_RLC: carryNew = bVal[DATA_W-1];
      RES_RRC: carryNew = bVal[0];
      default: carryNew = sumFull[DATA_W];
    endcase
  end

  assign dcNew   = sumLow[HALF_W];
  assign zeroNew = (result == '0);

endmodule

// File: rtl/alu8_status.sv
module alu8_status (
  input  logic clk,
  input  logic rstN,
  input  logic cWe,
  input  logic dcWe,
  input  logic zWe,
  input  logic cNew,
  input  logic dcNew,
  input  logic zNew,
  output logic carryQ,
  output logic dcQ,
  output logic zeroQ
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      carryQ <= 1'b0;
      dcQ    <= 1'b0;
      zeroQ  <= 1'b0;
    end else begin
      if (cWe)  carryQ <= cNew;
      if (dcWe) dcQ    <= dcNew;
      if (zWe)  zeroQ  <= zNew;
    end
  end

  // R8
  carry_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cWe |=> $stable(carryQ));
  // R8
  dc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dcWe |=> $stable(dcQ));
  // R8
  zero_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !zWe |=> $stable(zeroQ));

endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [3:0]        opCode,
  input  logic [DATA_W-1:0] wReg,
  input  logic [DATA_W-1:0] fileVal,
  input  logic [DATA_W-1:0] litVal,
  input  logic              useLit,
  input  logic              destFile,
  output logic [DATA_W-1:0] result,
  output logic              carryNext,
  output logic              dcNext,
  output logic              zeroNext,
  output logic              carryWe,
  output logic              dcWe,
  output logic              zeroWe,
  output logic              carryFlag,
  output logic              dcFlag,
  output logic              zeroFlag,
  output logic              writeW,
  output logic              writeF
);

  aluStrobe_t        strobe;
  logic [DATA_W-1:0] opB;

  assign opB = useLit ? litVal : fileVal;

  alu8_ctrl u_ctrl (
    .opValid (opValid),
    .opCode  (opCode),
    .strobe  (strobe)
  );

  alu8_dp #(.DATA_W(DATA_W)) u_dp (
    .strobe   (strobe),
    .wVal     (wReg),
    .bVal     (opB),
    .carryIn  (carryFlag),
    .result   (result),
    .carryNew (carryNext),
    .dcNew    (dcNext),
    .zeroNew  (zeroNext)
  );

  alu8_status u_status (
    .clk    (clk),
    .rstN   (rstN),
    .cWe    (strobe.cWe),
    .dcWe   (strobe.dcWe),
    .zWe    (strobe.zWe),
    .cNew   (carryNext),
    .dcNew  (dcNext),
    .zNew   (zeroNext),
    .carryQ (carryFlag),
    .dcQ    (dcFlag),
    .zeroQ  (zeroFlag)
  );

  assign carryWe = strobe.cWe;
  assign dcWe    = strobe.dcWe;
  assign zeroWe  = strobe.zWe;
  assign writeW  = opValid & ~destFile;
  assign writeF  = opValid &  destFile;

  // R2
  sub_borrow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_SUB) |-> (carryNext == (opB >= wReg)));
  // R12
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    zeroWe |=> (zeroFlag == ($past(result) == '0)));
  // R5
  rot_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (opCode == OP_RLC || opCode == OP_RRC)) |=> $stable(zeroFlag));
  // R9
  idle_we_chk: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |-> !(carryWe || dcWe || zeroWe));

endmodule

// File: tb/alu8_flags_tb.sv
`timescale 1ns/1ps
module alu8_flags_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       opValid = 1'b0;
  logic [3:0] opCode = '0;
  logic [7:0] wReg = '0, fileVal = '0, litVal = '0;
  logic       useLit = 1'b0, destFile = 1'b0;
  logic [7:0] result;
  logic       carryNext, dcNext, zeroNext, carryWe, dcWe, zeroWe;
  logic       carryFlag, dcFlag, zeroFlag, writeW, writeF;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  alu8_flags u_dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .wReg(wReg), .fileVal(fileVal), .litVal(litVal), .useLit(useLit),
    .destFile(destFile), .result(result), .carryNext(carryNext),
    .dcNext(dcNext), .zeroNext(zeroNext), .carryWe(carryWe), .dcWe(dcWe),
    .zeroWe(zeroWe), .carryFlag(carryFlag), .dcFlag(dcFlag),
    .zeroFlag(zeroFlag), .writeW(writeW), .writeF(writeF)
  );

  typedef struct packed {
    logic [3:0] op;
    logic [7:0] w;
    logic [7:0] b;
    logic [7:0] res;
    logic [2:0] we;   // {C, DC, Z}
    logic [2:0] flg;  // stored {C, DC, Z} after the edge
  } vec_t;

  localparam int NVEC = 23;
  localparam vec_t VECS [NVEC] = '{
    '{4'd0,  8'h3A, 8'h48, 8'h82, 3'b111, 3'b010},
    '{4'd0,  8'hF0, 8'h10, 8'h00, 3'b111, 3'b101},
    '{4'd1,  8'h03, 8'h05, 8'h02, 3'b111, 3'b110},
    '{4'd1,  8'h05, 8'h03, 8'hFE, 3'b111, 3'b000},
    '{4'd1,  8'h22, 8'h22, 8'h00, 3'b111, 3'b111},
    '{4'd1,  8'h01, 8'h10, 8'h0F, 3'b111, 3'b100},
    '{4'd2,  8'hF0, 8'h0F, 8'h00, 3'b001, 3'b101},
    '{4'd3,  8'h50, 8'h05, 8'h55, 3'b001, 3'b100},
    '{4'd4,  8'hAA, 8'hAA, 8'h00, 3'b001, 3'b101},
    '{4'd8,  8'h00, 8'h41, 8'h83, 3'b100, 3'b001},
    '{4'd9,  8'h00, 8'h03, 8'h01, 3'b100, 3'b101},
    '{4'd8,  8'h00, 8'h00, 8'h01, 3'b100, 3'b001},
    '{4'd9,  8'h00, 8'h80, 8'h40, 3'b100, 3'b001},
    '{4'd5,  8'h00, 8'hFF, 8'h00, 3'b001, 3'b001},
    '{4'd6,  8'h00, 8'hFF, 8'h00, 3'b001, 3'b001},
    '{4'd7,  8'h00, 8'h00, 8'hFF, 3'b001, 3'b000},
    '{4'd6,  8'h00, 8'h7F, 8'h80, 3'b001, 3'b000},
    '{4'd11, 8'h00, 8'h00, 8'h00, 3'b001, 3'b001},
    '{4'd12, 8'h00, 8'h5C, 8'h5C, 3'b001, 3'b000},
    '{4'd10, 8'h00, 8'hA5, 8'h5A, 3'b000, 3'b000},
    '{4'd0,  8'h0F, 8'h01, 8'h10, 3'b111, 3'b010},
    '{4'd13, 8'h00, 8'h33, 8'h33, 3'b000, 3'b010},
    '{4'd7,  8'h00, 8'h01, 8'h00, 3'b001, 3'b011}
  };

  function automatic string reqOf(input logic [3:0] op);
    case (op)
      4'd0:                    return "R1";
      4'd1:                    return "R2";
      4'd2, 4'd3, 4'd4:        return "R3";
      4'd8, 4'd9:              return "R5";
      4'd10, 4'd13, 4'd14, 4'd15: return "R6";
      default:                 return "R4";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [3:0] op, input logic [7:0] w,
                       input logic [7:0] b);
    @(negedge clk);
    opValid = v; opCode = op; wReg = w; fileVal = b;
    #1;
  endtask

  task automatic afterEdge();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #100000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    check({carryFlag, dcFlag, zeroFlag} == 3'b000, "R11", "flags in reset",
          {carryFlag, dcFlag, zeroFlag}, 0);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      drive(1'b1, VECS[i].op, VECS[i].w, VECS[i].b);
      check(result == VECS[i].res, reqOf(VECS[i].op), "result",
            result, VECS[i].res);
      // R9 enable pattern per operation
      check({carryWe, dcWe, zeroWe} == VECS[i].we, reqOf(VECS[i].op),
            "enables", {carryWe, dcWe, zeroWe}, VECS[i].we);
      afterEdge();
      // R8 / R12 stored flags
      check({carryFlag, dcFlag, zeroFlag} == VECS[i].flg, reqOf(VECS[i].op),
            "stored flags", {carryFlag, dcFlag, zeroFlag}, VECS[i].flg);
    end
    // flags now {0,1,1}

    // R9 / R8: add that would change every flag, but not valid
    drive(1'b0, 4'd0, 8'h80, 8'h80);
    check({carryWe, dcWe, zeroWe} == 3'b000, "R9", "enables idle",
          {carryWe, dcWe, zeroWe}, 0);
    // R10 no strobes when idle
    check({writeW, writeF} == 2'b00, "R10", "strobes idle", {writeW, writeF}, 0);
    afterEdge();
    check({carryFlag, dcFlag, zeroFlag} == 3'b011, "R8", "hold when idle",
          {carryFlag, dcFlag, zeroFlag}, 3'b011);

    // R7 literal select: literal 0x10, file 0x99, W 0x01 -> 0x11
    @(negedge clk);
    useLit = 1'b1; litVal = 8'h10;
    drive(1'b1, 4'd0, 8'h01, 8'h99);
    check(result == 8'h11, "R7", "literal operand", result, 8'h11);
    @(negedge clk);
    useLit = 1'b0;
    #1;
    check(result == 8'h9A, "R7", "file operand", result, 8'h9A);

    // R10 destination routing
    destFile = 1'b0;
    #1;
    check({writeW, writeF} == 2'b10, "R10", "dest W", {writeW, writeF}, 2'b10);
    destFile = 1'b1;
    #1;
    check({writeW, writeF} == 2'b01, "R10", "dest F", {writeW, writeF}, 2'b01);

    // R5 rotate uses stored carry: set C=1 via sub 5-3, then rotate left 0x00
    drive(1'b1, 4'd1, 8'h03, 8'h05);
    afterEdge();
    drive(1'b1, 4'd8, 8'h00, 8'h00);
    check(result == 8'h01, "R5", "rotate takes stored carry", result, 8'h01);
    check(carryNext == 1'b0, "R5", "rotate new carry", carryNext, 0);
    afterEdge();
    check({carryFlag, dcFlag, zeroFlag} == 3'b010, "R5", "rotate flags",
          {carryFlag, dcFlag, zeroFlag}, 3'b010);

    // R4 increment wrap does not set carry; R12 zero on wrap
    drive(1'b1, 4'd6, 8'h00, 8'hFF);
    afterEdge();
    check({carryFlag, dcFlag, zeroFlag} == 3'b011, "R4", "inc wrap keeps C",
          {carryFlag, dcFlag, zeroFlag}, 3'b011);

    // R11 reset mid-run clears stored flags
    drive(1'b0, 4'd0, 8'h00, 8'h00);
    rstN = 1'b0;
    #1;
    check({carryFlag, dcFlag, zeroFlag} == 3'b000, "R11", "async reset",
          {carryFlag, dcFlag, zeroFlag}, 0);
    @(negedge clk);
    rstN = 1'b1;
    afterEdge();

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule